// File: doc/BRIEF.md
# Misaligned Access Pair Splitter

This block sits between the load/store function units and a small line buffer built from 16-byte lines. It takes one request, made of a unit number, a byte address, a length code and (for stores) register data. It turns the request into one or two line-aligned sub-operations. Each sub-operation carries its line index, a byte-enable mask over the 16 bytes of the line, a start offset into the register value, a tag and the store data already moved into line position. An access that stays inside one line yields a single sub-operation. An access that runs past the end of a line yields a pair: the low part goes to the addressed line and the rest goes to the next line.

Load data returns as two line-wide words, one from each half. The block rejoins them into the register value by using the mask and start offset each half was given. Both paths are registered, so results appear one clock after the request.

Top module: `misaligned_pair_splitter`

## Requirements
- R1: While `rst_n` is low at a rising edge, `lo_valid`, `hi_valid` and `ld_out_valid` are 0 after that edge.
- R2: `lo_line` equals the request address shifted right by 4. `hi_line` equals that value plus one, wrapping at the line-index width.
- R3: Length code 0..4 selects 1, 2, 4, 8 or 16 bytes. The 32-bit mask ((1<<bytes)-1)<<addr[3:0] is formed, and its bits 15:0 go out on `lo_mask` and its bits 31:16 on `hi_mask`.
- R4: `lo_valid` is 1 one cycle after an accepted request. `hi_valid` is 1 only when addr[3:0]+bytes exceeds 16. Both are 0 one cycle after a cycle with `req_valid` low.
- R5: `lo_start` is 0. `hi_start` equals 16 - addr[3:0], which is the number of bytes taken by the low half.
- R6: The tag carries the unit one-hot in bits NUM_FU-1:0, with bit `req_unit` set. Bit NUM_FU is the half select: 0 on `lo_tag` and 1 on `hi_tag`.
- R7: The store data, zero-extended to 256 bits and shifted left by addr[3:0]*8, gives `lo_wdata` from bits 127:0 and `hi_wdata` from bits 255:128.
- R8: Length codes 5, 6 and 7 are rejected. Neither sub-operation becomes valid for them.
- R9: One cycle after `ld_valid`, `ld_out_data` is the OR of the contributions of each half in use. A half contributes the bytes its mask selects, moved down to the lowest masked byte and placed at byte `start` of the register. The high half is ignored when `ld_hi_valid` is 0. `ld_out_valid` follows `ld_valid` by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_unit | input | $clog2(NUM_FU) | Originating unit number |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | 3 | Length code (0..4 = 1,2,4,8,16 bytes) |
| req_wdata | input | 128 | Store data in register position |
| lo_valid | output | 1 | First sub-operation valid |
| lo_line | output | ADDR_W-4 | First line index |
| lo_mask | output | 16 | First byte enables |
| lo_start | output | 4 | First start offset |
| lo_tag | output | NUM_FU+1 | First tag (half bit, unit one-hot) |
| lo_wdata | output | 128 | First store data in line position |
| hi_valid | output | 1 | Second sub-operation valid |
| hi_line | output | ADDR_W-4 | Second line index |
| hi_mask | output | 16 | Second byte enables |
| hi_start | output | 4 | Second start offset |
| hi_tag | output | NUM_FU+1 | Second tag |
| hi_wdata | output | 128 | Second store data in line position |
| ld_valid | input | 1 | Returning load, first half present |
| ld_lo_data | input | 128 | First half line data |
| ld_lo_mask | input | 16 | First half mask |
| ld_lo_start | input | 4 | First half start |
| ld_hi_valid | input | 1 | Second half present |
| ld_hi_data | input | 128 | Second half line data |
| ld_hi_mask | input | 16 | Second half mask |
| ld_hi_start | input | 4 | Second half start |
| ld_out_valid | output | 1 | Merged load valid |
| ld_out_data | output | 128 | Merged register value |

## Verification
All state is one register stage, so any fault shows at the ports in the cycle after the request that exposes it. A wrong crossing decision shows as a missing or extra `hi_valid`, together with masks that do not add up to the access length. A start or mask error in the merge path shows as shifted or lost bytes in `ld_out_data` on the next cycle. The test accesses sit at offsets 0, 12 to 15 and near the top of the address space, so that off-by-one faults in the boundary test, in the wrap of the line index and in the high-half start offset each change a visible field.

// File: rtl/lsp_pkg.sv
`timescale 1ns/1ps
// Shared constants for the pair splitter: line geometry and length coding.
package lsp_pkg;
    localparam int LINE_BYTES = 16;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int DATA_W     = LINE_BYTES * 8;
    localparam int LEN_W      = 3;
    localparam int MAX_LEN_CODE = OFF_W;  // code 4 -> 16 bytes
endpackage

// File: rtl/lsp_mask_gen.sv
`timescale 1ns/1ps
// Byte-mask generator. Decodes the length code, builds the two-line byte mask
// and says whether the access crosses into the next line.
// Assumes the offset is the address modulo the line size.
module lsp_mask_gen
    import lsp_pkg::*;
(
    input  logic [OFF_W-1:0]      offset,
    input  logic [LEN_W-1:0]      len_code,
    output logic                  legal,
    output logic [LINE_BYTES-1:0] mask_lo,
    output logic [LINE_BYTES-1:0] mask_hi,
    output logic                  crosses,
    output logic [OFF_W-1:0]      hi_start
);
    logic [OFF_W:0]          nbytes;
    logic [2*LINE_BYTES-1:0] span;

    // Decode length code and form the shifted span over two lines.
    always_comb begin
        legal   = (len_code <= LEN_W'(MAX_LEN_CODE));
        nbytes  = legal ? (OFF_W+1)'(1) << len_code : '0;
        span    = ((32'(1) << nbytes) - 32'(1)) << offset;
        mask_lo = span[LINE_BYTES-1:0];
        mask_hi = span[2*LINE_BYTES-1:LINE_BYTES];
        crosses = |mask_hi;
        hi_start = OFF_W'(LINE_BYTES) - offset;
    end

    // R3: the two halves together always hold exactly the access length.
    always_comb begin
        if (legal)
            a_r3_mask_count: assert ($countones(span) == int'(nbytes));
    end
endmodule

// File: rtl/lsp_store_align.sv
`timescale 1ns/1ps
// Store aligner. Moves register data up by offset bytes into a two-line window
// and hands each half its line-wide slice. Purely combinational.
module lsp_store_align
    import lsp_pkg::*;
(
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lo_data,
    output logic [DATA_W-1:0] hi_data
);
    logic [2*DATA_W-1:0] window;

    // Shift zero-extended data into line position.
    always_comb begin
        window  = {{DATA_W{1'b0}}, wdata} << {offset, 3'b000};
        lo_data = window[DATA_W-1:0];
        hi_data = window[2*DATA_W-1:DATA_W];
    end
endmodule

// File: rtl/lsp_load_merge.sv
`timescale 1ns/1ps
// Load merger. Rejoins the line data of one or two halves into a register
// value using each half's mask and start offset; one register stage.
// Assumes each mask is a contiguous run of bytes.
module lsp_load_merge
    import lsp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_valid,
    input  logic [DATA_W-1:0]     lo_data,
    input  logic [LINE_BYTES-1:0] lo_mask,
    input  logic [OFF_W-1:0]      lo_start,
    input  logic                  hi_valid,
    input  logic [DATA_W-1:0]     hi_data,
    input  logic [LINE_BYTES-1:0] hi_mask,
    input  logic [OFF_W-1:0]      hi_start,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_data
);
    // Index of the lowest set byte in a mask (0 when empty).
    function automatic logic [OFF_W-1:0] first_byte(input logic [LINE_BYTES-1:0] m);
        logic [OFF_W-1:0] idx;
        idx = '0;
        for (int i = LINE_BYTES - 1; i >= 0; i--)
            if (m[i]) idx = OFF_W'(i);
        return idx;
    endfunction

    // Widen a byte mask to a bit mask.
    function automatic logic [DATA_W-1:0] widen(input logic [LINE_BYTES-1:0] m);
        logic [DATA_W-1:0] w;
        for (int i = 0; i < LINE_BYTES; i++)
            w[i*8 +: 8] = {8{m[i]}};
        return w;
    endfunction

    // Contribution of one half, placed at its start byte.
    function automatic logic [DATA_W-1:0] place(input logic [DATA_W-1:0] d,
                                                input logic [LINE_BYTES-1:0] m,
                                                input logic [OFF_W-1:0] s);
        logic [OFF_W-1:0] f;
        f = first_byte(m);
        return ((d >> {f, 3'b000}) & widen(m >> f)) << {s, 3'b000};
    endfunction

    logic [DATA_W-1:0] merged;

    // Combine both halves; high half only when flagged.
    always_comb begin
        merged = place(lo_data, lo_mask, lo_start);
        if (hi_valid)
            merged = merged | place(hi_data, hi_mask, hi_start);
    end

    // Register merged value and its valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ld_valid;
            out_data  <= ld_valid ? merged : '0;
        end
    end

    // R9: output valid only follows an incoming load.
    a_r9_out_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(ld_valid));
    // R1: reset clears the merged valid.
    a_r1_ld_reset: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: rtl/misaligned_pair_splitter.sv
`timescale 1ns/1ps
// Misaligned access pair splitter. Splits one load/store request into one or
// two tagged, byte-masked line operations and rejoins returning load data.
// Assumes req_unit < NUM_FU; results appear one cycle after the request.
module misaligned_pair_splitter
    import lsp_pkg::*;
#(
    parameter int NUM_FU = 4,
    parameter int ADDR_W = 32,
    localparam int FU_W   = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int TAG_W  = NUM_FU + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [FU_W-1:0]       req_unit,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  lo_valid,
    output logic [LINE_W-1:0]     lo_line,
    output logic [LINE_BYTES-1:0] lo_mask,
    output logic [OFF_W-1:0]      lo_start,
    output logic [TAG_W-1:0]      lo_tag,
    output logic [DATA_W-1:0]     lo_wdata,
    output logic                  hi_valid,
    output logic [LINE_W-1:0]     hi_line,
    output logic [LINE_BYTES-1:0] hi_mask,
    output logic [OFF_W-1:0]      hi_start,
    output logic [TAG_W-1:0]      hi_tag,
    output logic [DATA_W-1:0]     hi_wdata,
    input  logic                  ld_valid,
    input  logic [DATA_W-1:0]     ld_lo_data,
    input  logic [LINE_BYTES-1:0] ld_lo_mask,
    input  logic [OFF_W-1:0]      ld_lo_start,
    input  logic                  ld_hi_valid,
    input  logic [DATA_W-1:0]     ld_hi_data,
    input  logic [LINE_BYTES-1:0] ld_hi_mask,
    input  logic [OFF_W-1:0]      ld_hi_start,
    output logic                  ld_out_valid,
    output logic [DATA_W-1:0]     ld_out_data
);
    logic [OFF_W-1:0]      offset;
    logic [LINE_W-1:0]     base_line;
    logic                  legal, crosses;
    logic [LINE_BYTES-1:0] m_lo, m_hi;
    logic [OFF_W-1:0]      s_hi;
    logic [DATA_W-1:0]     w_lo, w_hi;
    logic [NUM_FU-1:0]     unit_oh;

    assign offset    = req_addr[OFF_W-1:0];
    assign base_line = req_addr[ADDR_W-1:OFF_W];
    assign unit_oh   = NUM_FU'(1) << req_unit;

    lsp_mask_gen u_mask (
        .offset   (offset),
        .len_code (req_len),
        .legal    (legal),
        .mask_lo  (m_lo),
        .mask_hi  (m_hi),
        .crosses  (crosses),
        .hi_start (s_hi)
    );

    lsp_store_align u_align (
        .offset  (offset),
        .wdata   (req_wdata),
        .lo_data (w_lo),
        .hi_data (w_hi)
    );

    // Per-half next values and registers, index 0 = low half, 1 = high half.
    logic [1:0]                 h_valid_d, h_valid_q;
    logic [1:0][LINE_W-1:0]     h_line_d, h_line_q;
    logic [1:0][LINE_BYTES-1:0] h_mask_d, h_mask_q;
    logic [1:0][OFF_W-1:0]      h_start_d, h_start_q;
    logic [1:0][TAG_W-1:0]      h_tag_d, h_tag_q;
    logic [1:0][DATA_W-1:0]     h_data_d, h_data_q;

    for (genvar h = 0; h < 2; h++) begin : g_half
        // Select this half's fields from the shared decode.
        always_comb begin
            h_valid_d[h] = req_valid && legal && ((h == 0) || crosses);
            h_line_d[h]  = base_line + LINE_W'(h);
            h_mask_d[h]  = (h == 0) ? m_lo : m_hi;
            h_start_d[h] = (h == 0) ? '0 : s_hi;
            h_tag_d[h]   = {1'(h), unit_oh};
            h_data_d[h]  = (h == 0) ? w_lo : w_hi;
        end

        // Hold this half's sub-operation for one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                h_valid_q[h] <= 1'b0;
                h_line_q[h]  <= '0;
                h_mask_q[h]  <= '0;
                h_start_q[h] <= '0;
                h_tag_q[h]   <= '0;
                h_data_q[h]  <= '0;
            end else begin
                h_valid_q[h] <= h_valid_d[h];
                h_line_q[h]  <= h_line_d[h];
                h_mask_q[h]  <= h_valid_d[h] ? h_mask_d[h] : '0;
                h_start_q[h] <= h_start_d[h];
                h_tag_q[h]   <= h_valid_d[h] ? h_tag_d[h] : '0;
                h_data_q[h]  <= h_data_d[h];
            end
        end
    end

    assign lo_valid = h_valid_q[0];
    assign lo_line  = h_line_q[0];
    assign lo_mask  = h_mask_q[0];
    assign lo_start = h_start_q[0];
    assign lo_tag   = h_tag_q[0];
    assign lo_wdata = h_data_q[0];
    assign hi_valid = h_valid_q[1];
    assign hi_line  = h_line_q[1];
    assign hi_mask  = h_mask_q[1];
    assign hi_start = h_start_q[1];
    assign hi_tag   = h_tag_q[1];
    assign hi_wdata = h_data_q[1];

    lsp_load_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .lo_data   (ld_lo_data),
        .lo_mask   (ld_lo_mask),
        .lo_start  (ld_lo_start),
        .hi_valid  (ld_hi_valid),
        .hi_data   (ld_hi_data),
        .hi_mask   (ld_hi_mask),
        .hi_start  (ld_hi_start),
        .out_valid (ld_out_valid),
        .out_data  (ld_out_data)
    );

    // R1: reset clears both sub-operation valids.
    a_r1_split_reset: assert property (@(posedge clk)
        !rst_n |=> (!lo_valid && !hi_valid));
    // R4: the second half never appears without the first.
    a_r4_hi_needs_lo: assert property (@(posedge clk) disable iff (!rst_n)
        hi_valid |-> lo_valid);
    // R4: a valid sub-operation follows a request.
    a_r4_from_request: assert property (@(posedge clk) disable iff (!rst_n)
        lo_valid |-> $past(req_valid));
    // R3: a pair meets at the line boundary.
    a_r3_pair_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        hi_valid |-> (lo_mask[LINE_BYTES-1] && hi_mask[0]));
    // R5: the high half starts where the low half's bytes end.
    a_r5_start_matches: assert property (@(posedge clk) disable iff (!rst_n)
        hi_valid |-> (int'(hi_start) == $countones(lo_mask) && lo_start == '0));
    // R6: tags name exactly one unit and the right half.
    a_r6_tag_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        lo_valid |-> ($countones(lo_tag[NUM_FU-1:0]) == 1 && !lo_tag[NUM_FU]));
    a_r6_hi_tag: assert property (@(posedge clk) disable iff (!rst_n)
        hi_valid |-> (hi_tag[NUM_FU] && hi_tag[NUM_FU-1:0] == lo_tag[NUM_FU-1:0]));
    // R2: the two line indices are consecutive.
    a_r2_lines_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
        hi_valid |-> (hi_line == lo_line + LINE_W'(1)));
endmodule

// File: tb/misaligned_pair_splitter_bench.sv
`timescale 1ns/1ps
module misaligned_pair_splitter_bench;
    localparam int NUM_FU = 4;
    localparam int ADDR_W = 32;
    localparam int LW     = ADDR_W - 4;

    typedef struct packed {
        logic [1:0]  unit;
        logic [31:0] addr;
        logic [2:0]  len;
        logic        exp_hi;
        logic [15:0] exp_m0;
        logic [15:0] exp_m1;
        logic [3:0]  exp_s1;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h0000_1000, 3'd0, 1'b0, 16'h0001, 16'h0000, 4'd0},
        '{2'd1, 32'h0000_1003, 3'd1, 1'b0, 16'h0018, 16'h0000, 4'd0},
        '{2'd2, 32'h0000_100E, 3'd1, 1'b0, 16'hC000, 16'h0000, 4'd0},
        '{2'd3, 32'h0000_100F, 3'd1, 1'b1, 16'h8000, 16'h0001, 4'd1},
        '{2'd0, 32'h0000_2009, 3'd3, 1'b1, 16'hFE00, 16'h0001, 4'd7},
        '{2'd1, 32'h0000_2000, 3'd4, 1'b0, 16'hFFFF, 16'h0000, 4'd0},
        '{2'd2, 32'h0000_2004, 3'd4, 1'b1, 16'hFFF0, 16'h000F, 4'd12},
        '{2'd3, 32'h0000_200C, 3'd2, 1'b0, 16'hF000, 16'h0000, 4'd0},
        '{2'd0, 32'h0000_200D, 3'd2, 1'b1, 16'hE000, 16'h0001, 4'd3},
        '{2'd1, 32'hFFFF_FFF8, 3'd4, 1'b1, 16'hFF00, 16'h00FF, 4'd8}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_unit = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0] req_len = '0;
    logic [127:0] req_wdata = '0;
    logic lo_valid, hi_valid, ld_out_valid;
    logic [LW-1:0] lo_line, hi_line;
    logic [15:0] lo_mask, hi_mask;
    logic [3:0] lo_start, hi_start;
    logic [NUM_FU:0] lo_tag, hi_tag;
    logic [127:0] lo_wdata, hi_wdata, ld_out_data;
    logic ld_valid = 1'b0, ld_hi_valid = 1'b0;
    logic [127:0] ld_lo_data = '0, ld_hi_data = '0;
    logic [15:0] ld_lo_mask = '0, ld_hi_mask = '0;
    logic [3:0] ld_lo_start = '0, ld_hi_start = '0;

    int checks = 0;
    int fails = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    misaligned_pair_splitter #(.NUM_FU(NUM_FU), .ADDR_W(ADDR_W)) u_misaligned_pair_splitter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_unit(req_unit),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .lo_valid(lo_valid), .lo_line(lo_line), .lo_mask(lo_mask), .lo_start(lo_start),
        .lo_tag(lo_tag), .lo_wdata(lo_wdata),
        .hi_valid(hi_valid), .hi_line(hi_line), .hi_mask(hi_mask), .hi_start(hi_start),
        .hi_tag(hi_tag), .hi_wdata(hi_wdata),
        .ld_valid(ld_valid), .ld_lo_data(ld_lo_data), .ld_lo_mask(ld_lo_mask),
        .ld_lo_start(ld_lo_start), .ld_hi_valid(ld_hi_valid), .ld_hi_data(ld_hi_data),
        .ld_hi_mask(ld_hi_mask), .ld_hi_start(ld_hi_start),
        .ld_out_valid(ld_out_valid), .ld_out_data(ld_out_data)
    );

    task automatic check(input logic ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] len_bits(input logic [2:0] code);
        int nb;
        nb = 1 << code;
        if (nb >= 16) return '1;
        return (128'(1) << (nb * 8)) - 128'(1);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        req_valid = 1'b1; req_len = 3'd4; ld_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(!lo_valid && !hi_valid, "R1 split valids in reset", {lo_valid, hi_valid}, 0);
        check(!ld_out_valid, "R1 merge valid in reset", ld_out_valid, 0);
        req_valid = 1'b0; ld_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk: R2..R7 and R9.
        for (int i = 0; i < NV; i++) begin
            logic [127:0] v;
            logic [255:0] win, sw;
            logic [3:0] off;
            v   = {32'hA5C3_0000 + 32'(i), 32'h1122_3344, 32'h5566_7788, 32'h99AA_BBCC + 32'(i)};
            off = VECS[i].addr[3:0];
            req_valid = 1'b1; req_unit = VECS[i].unit; req_addr = VECS[i].addr;
            req_len = VECS[i].len; req_wdata = v;
            win = {128'b0, v & len_bits(VECS[i].len)} << (off * 8);
            ld_valid = 1'b1; ld_hi_valid = VECS[i].exp_hi;
            ld_lo_data = win[127:0]; ld_hi_data = win[255:128];
            ld_lo_mask = VECS[i].exp_m0; ld_hi_mask = VECS[i].exp_m1;
            ld_lo_start = 4'd0; ld_hi_start = VECS[i].exp_s1;
            @(negedge clk);
            sw = {128'b0, v} << (off * 8);
            check(lo_valid == 1'b1, "R4 lo_valid", lo_valid, 1);
            check(hi_valid == VECS[i].exp_hi, "R4 hi_valid", hi_valid, VECS[i].exp_hi);
            check(lo_line == VECS[i].addr[31:4], "R2 lo_line", lo_line, VECS[i].addr[31:4]);
            check(lo_mask == VECS[i].exp_m0, "R3 lo_mask", lo_mask, VECS[i].exp_m0);
            check(lo_start == 4'd0, "R5 lo_start", lo_start, 0);
            check(lo_tag == {1'b0, 4'(1 << VECS[i].unit)}, "R6 lo_tag", lo_tag,
                  {1'b0, 4'(1 << VECS[i].unit)});
            check(lo_wdata == sw[127:0], "R7 lo_wdata", lo_wdata, sw[127:0]);
            if (VECS[i].exp_hi) begin
                check(hi_line == VECS[i].addr[31:4] + 28'd1, "R2 hi_line", hi_line,
                      VECS[i].addr[31:4] + 28'd1);
                check(hi_mask == VECS[i].exp_m1, "R3 hi_mask", hi_mask, VECS[i].exp_m1);
                check(hi_start == VECS[i].exp_s1, "R5 hi_start", hi_start, VECS[i].exp_s1);
                check(hi_tag == {1'b1, 4'(1 << VECS[i].unit)}, "R6 hi_tag", hi_tag,
                      {1'b1, 4'(1 << VECS[i].unit)});
                check(hi_wdata == sw[255:128], "R7 hi_wdata", hi_wdata, sw[255:128]);
            end
            check(ld_out_valid, "R9 ld_out_valid", ld_out_valid, 1);
            check(ld_out_data == (v & len_bits(VECS[i].len)), "R9 merged load",
                  ld_out_data, v & len_bits(VECS[i].len));
        end

        // R4: idle cycle drops both valids.
        req_valid = 1'b0; ld_valid = 1'b0;
        @(negedge clk);
        check(!lo_valid && !hi_valid, "R4 idle valids", {lo_valid, hi_valid}, 0);
        check(!ld_out_valid, "R9 idle merge valid", ld_out_valid, 0);

        // R8: rejected length codes.
        for (int c = 5; c < 8; c++) begin
            req_valid = 1'b1; req_addr = 32'h0000_300F; req_len = 3'(c);
            @(negedge clk);
            check(!lo_valid && !hi_valid, "R8 illegal length", {lo_valid, hi_valid}, 0);
        end

        // R9: high half ignored when its valid is low.
        req_valid = 1'b0;
        ld_valid = 1'b1; ld_hi_valid = 1'b0;
        ld_lo_data = {8'h5A, 120'b0}; ld_lo_mask = 16'h8000; ld_lo_start = 4'd0;
        ld_hi_data = {120'b0, 8'hE7}; ld_hi_mask = 16'h0001; ld_hi_start = 4'd1;
        @(negedge clk);
        check(ld_out_data == 128'h5A, "R9 high half ignored", ld_out_data, 128'h5A);
        ld_hi_valid = 1'b1;
        @(negedge clk);
        check(ld_out_data == 128'hE75A, "R9 high half joined", ld_out_data, 128'hE75A);

        // R1: reset mid-stream clears outputs.
        req_valid = 1'b1; req_len = 3'd4; req_addr = 32'h8;
        rst_n = 1'b0;
        @(negedge clk);
        check(!lo_valid && !hi_valid && !ld_out_valid, "R1 reset mid-stream",
              {lo_valid, hi_valid, ld_out_valid}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule